// File: doc/BRIEF.md
# System Options Register with Watchdog and Stop Trap

This block holds the chip's system options in one 8-bit register reached over a simple bus: an address-decoded write strobe, write data and read data. Three of its fields are frozen by the first write after reset: the watchdog enable, the watchdog period select and the stop permission. Once frozen, these fields set how the built-in watchdog behaves and what happens when the processor asks to stop. Two more fields select the function of two pins. They stay writable for as long as the chip runs.

The watchdog counts bus clocks. Software clears it with a service strobe. If the selected period runs out before a service, the block raises a one-cycle reset request. A stop request while stop is not permitted raises a one-cycle illegal-opcode reset request and does not grant the stop. The reset controller, the processor and the pads sit outside this block.

Top module: `sysopt_ctrl`

## Requirements
- R1: After reset the register reads 8'hC3: bit 7 watchdog enable = 1, bit 6 long-period select = 1, bit 5 stop permission = 0, bit 1 debug-pin enable = 1 and bit 0 reset-pin enable = 1. `dbg_pin_en` and `rst_pin_en` are both 1.
- R2: The first write after reset stores bits 7:5 and sets a lock. The lock is cleared only by reset. Every later write leaves bits 7:5 unchanged.
- R3: Bits 1:0 take the write data on every write, whether or not the lock is set. They drive `dbg_pin_en` (bit 1) and `rst_pin_en` (bit 0) from the clock edge that samples the write.
- R4: Bits 4:2 always read 0.
- R5: With the watchdog enabled, `wdog_rst_req` rises P clock edges after the last restart point: the reset release, a service, the locking write or a previous request. P = 2^(LONG_EXP-TIME_SHIFT) when bit 6 is 1 and 2^(SHORT_EXP-TIME_SHIFT) when it is 0. The defaults are 20, 18 and 0.
- R6: A service strobe sampled on a clock edge restarts the count from zero at that edge.
- R7: With the watchdog disabled, the count stays at zero and `wdog_rst_req` never rises.
- R8: Each reset request (`wdog_rst_req` or `illop_rst_req`) is high for exactly one cycle. Counting resumes from zero after a watchdog request.
- R9: A `stop_req` sampled while stop permission is 0 gives a one-cycle `illop_rst_req` on the next cycle and no `stop_grant`.
- R10: A `stop_req` sampled while stop permission is 1 gives a one-cycle `stop_grant` on the next cycle and no `illop_rst_req`.
- R11: The locking write restarts the watchdog count. The new period select applies from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Address-decoded write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read data |
| wdog_service | input | 1 | Watchdog service strobe |
| stop_req | input | 1 | Stop request from the processor |
| wdog_rst_req | output | 1 | Watchdog timeout reset request pulse |
| illop_rst_req | output | 1 | Illegal-stop reset request pulse |
| stop_grant | output | 1 | Stop accepted pulse |
| dbg_pin_en | output | 1 | Debug pin function enable |
| rst_pin_en | output | 1 | Reset pin function enable |

## Verification
Read data follows the register combinationally, so a write is checked at the falling edge right after the rising edge that samples it. Both stop outcomes come from one register stage, so they are checked one cycle after the request is sampled. The watchdog request is due exactly P rising edges after a restart point. The bench counts falling edges from the restart and expects the first high sample at count P, followed by a low sample on the next falling edge. The bench drives inputs on falling edges and samples outputs there, so every expected value lines up with a known rising edge.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_WD_EN  = 7;
  localparam int BIT_WD_LNG = 6;
  localparam int BIT_STOPOK = 5;
  localparam int BIT_DBGPIN = 1;
  localparam int BIT_RSTPIN = 0;
  localparam logic [REG_W-1:0] RESET_VAL = 8'hC3;

  typedef struct packed {
    logic wd_en;
    logic wd_long;
    logic stop_ok;
  } frozen_t;

  typedef struct packed {
    logic dbg;
    logic rstp;
  } pins_t;

  function automatic frozen_t take_frozen(input logic [REG_W-1:0] d);
    frozen_t f;
    f.wd_en   = d[BIT_WD_EN];
    f.wd_long = d[BIT_WD_LNG];
    f.stop_ok = d[BIT_STOPOK];
    return f;
  endfunction

  function automatic pins_t take_pins(input logic [REG_W-1:0] d);
    pins_t p;
    p.dbg  = d[BIT_DBGPIN];
    p.rstp = d[BIT_RSTPIN];
    return p;
  endfunction

  function automatic logic [REG_W-1:0] compose_read(input frozen_t f, input pins_t p);
    logic [REG_W-1:0] r;
    r = '0;
    r[BIT_WD_EN]  = f.wd_en;
    r[BIT_WD_LNG] = f.wd_long;
    r[BIT_STOPOK] = f.stop_ok;
    r[BIT_DBGPIN] = p.dbg;
    r[BIT_RSTPIN] = p.rstp;
    return r;
  endfunction

  function automatic int unsigned period_exp(input logic wd_long, input int unsigned long_exp,
                                             input int unsigned short_exp, input int unsigned shift);
    return wd_long ? (long_exp - shift) : (short_exp - shift);
  endfunction
endpackage

// File: rtl/sysopt_regfile.sv
module sysopt_regfile
  import sysopt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output frozen_t          frozen_o,
  output pins_t            pins_o,
  output logic             lock_o,
  output logic             commit_o,
  output logic [REG_W-1:0] rd_data
);
  frozen_t frozen_q;
  pins_t   pins_q;
  logic    lock_q;

  assign commit_o = wr_en & ~lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= take_frozen(RESET_VAL);
      pins_q   <= take_pins(RESET_VAL);
      lock_q   <= 1'b0;
    end else begin
      if (commit_o) begin
        frozen_q <= take_frozen(wr_data);
        lock_q   <= 1'b1;
      end
      if (wr_en) pins_q <= take_pins(wr_data);
    end
  end

  assign frozen_o = frozen_q;
  assign pins_o   = pins_q;
  assign lock_o   = lock_q;
  assign rd_data  = compose_read(frozen_q, pins_q);
endmodule

// File: rtl/sysopt_wdog.sv
module sysopt_wdog
  import sysopt_pkg::*;
#(
  parameter int unsigned LONG_EXP   = 20,
  parameter int unsigned SHORT_EXP  = 18,
  parameter int unsigned TIME_SHIFT = 0,
  localparam int unsigned CW        = LONG_EXP - TIME_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          long_sel,
  input  logic          service,
  input  logic          restart,
  output logic [CW-1:0] count_o,
  output logic          expire_o,
  output logic          req_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   limit;
  logic          req_q;
  logic          clear;

  always_comb begin
    limit = ((CW+1)'(1) << period_exp(long_sel, LONG_EXP, SHORT_EXP, TIME_SHIFT)) - (CW+1)'(1);
  end

  assign clear    = ~enable | service | restart;
  assign expire_o = ~clear & ({1'b0, cnt_q} == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= expire_o;
      if (clear || expire_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CW'(1);
    end
  end

  assign count_o = cnt_q;
  assign req_o   = req_q;
endmodule

// File: rtl/sysopt_stopgate.sv
module sysopt_stopgate (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_ok,
  input  logic stop_req,
  output logic trap_o,
  output logic grant_o,
  output logic illop_o
);
  logic grant_q, illop_q;

  assign trap_o = stop_req & ~stop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      illop_q <= 1'b0;
    end else begin
      grant_q <= stop_req & stop_ok;
      illop_q <= trap_o;
    end
  end

  assign grant_o = grant_q;
  assign illop_o = illop_q;
endmodule

// File: rtl/sysopt_ctrl.sv
module sysopt_ctrl
  import sysopt_pkg::*;
#(
  parameter int unsigned LONG_EXP   = 20,
  parameter int unsigned SHORT_EXP  = 18,
  parameter int unsigned TIME_SHIFT = 0,
  localparam int unsigned CW        = LONG_EXP - TIME_SHIFT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       wdog_service,
  input  logic       stop_req,
  output logic       wdog_rst_req,
  output logic       illop_rst_req,
  output logic       stop_grant,
  output logic       dbg_pin_en,
  output logic       rst_pin_en
);
  frozen_t       frozen_w;
  pins_t         pins_w;
  logic          lock_w;
  logic          commit_w;
  logic [CW-1:0] wd_count_w;
  logic          wd_expire_w;
  logic          trap_w;

  sysopt_regfile u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .frozen_o(frozen_w), .pins_o(pins_w), .lock_o(lock_w),
    .commit_o(commit_w), .rd_data(rd_data)
  );

  sysopt_wdog #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP), .TIME_SHIFT(TIME_SHIFT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .enable(frozen_w.wd_en), .long_sel(frozen_w.wd_long),
    .service(wdog_service), .restart(commit_w), .count_o(wd_count_w),
    .expire_o(wd_expire_w), .req_o(wdog_rst_req)
  );

  sysopt_stopgate u_stop (
    .clk(clk), .rst_n(rst_n), .stop_ok(frozen_w.stop_ok), .stop_req(stop_req),
    .trap_o(trap_w), .grant_o(stop_grant), .illop_o(illop_rst_req)
  );

  assign dbg_pin_en = pins_w.dbg;
  assign rst_pin_en = pins_w.rstp;
endmodule

// File: rtl/sysopt_ctrl_chk.sv
module sysopt_ctrl_chk #(
  parameter int unsigned CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          stop_req,
  input logic [7:0]    rd_data,
  input logic          lock_w,
  input logic          commit_w,
  input logic          wd_en,
  input logic          stop_ok,
  input logic [CW-1:0] wd_count_w,
  input logic          wd_expire_w,
  input logic          trap_w,
  input logic          wdog_rst_req,
  input logic          illop_rst_req,
  input logic          stop_grant
);
  assert_frozen_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w |=> $stable(rd_data[7:5]));
  assert_commit_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && commit_w) |=> lock_w);
  assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:2] == 3'b000);
  assert_commit_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> (wd_count_w == '0) && !wdog_rst_req);
  assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (wd_count_w == '0) && !wdog_rst_req);
  assert_expire_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire_w |=> wdog_rst_req && (wd_count_w == '0));
  assert_wdog_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |=> !wdog_rst_req);
  assert_illop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illop_rst_req |=> !illop_rst_req);
  assert_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_w |=> illop_rst_req && !stop_grant);
  assert_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && stop_ok) |=> stop_grant && !illop_rst_req);
endmodule

bind sysopt_ctrl sysopt_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .stop_req(stop_req), .rd_data(rd_data),
  .lock_w(lock_w), .commit_w(commit_w), .wd_en(frozen_w.wd_en), .stop_ok(frozen_w.stop_ok),
  .wd_count_w(wd_count_w), .wd_expire_w(wd_expire_w), .trap_w(trap_w),
  .wdog_rst_req(wdog_rst_req), .illop_rst_req(illop_rst_req), .stop_grant(stop_grant)
);

// File: tb/sysopt_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysopt_ctrl_tb_top;
  localparam int unsigned LEXP = 20, SEXP = 18, SHIFT = 12;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wdog_service = 0, stop_req = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic wdog_rst_req, illop_rst_req, stop_grant, dbg_pin_en, rst_pin_en;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sysopt_ctrl #(.LONG_EXP(LEXP), .SHORT_EXP(SEXP), .TIME_SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wdog_service(wdog_service), .stop_req(stop_req), .wdog_rst_req(wdog_rst_req),
    .illop_rst_req(illop_rst_req), .stop_grant(stop_grant),
    .dbg_pin_en(dbg_pin_en), .rst_pin_en(rst_pin_en)
  );

  function automatic int exp_period(input logic lng);
    return 1 << (lng ? (LEXP - SHIFT) : (SEXP - SHIFT));
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] frozen_src, input logic [7:0] pin_src);
    return (frozen_src & 8'hE0) | (pin_src & 8'h03);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; wdog_service = 0; stop_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_pulse(input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(negedge clk);
      k++;
      if (wdog_rst_req) return;
    end
    k = -1;
  endtask

  task automatic quiet_window(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdog_rst_req) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic stop_probe(input string req, input logic exp_grant);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    chk({req, " grant"}, stop_grant, exp_grant);
    chk({req, " illop"}, illop_rst_req, !exp_grant);
    @(negedge clk);
    chk({req, " single"}, {stop_grant, illop_rst_req}, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k;
    logic [7:0] model;
    logic prev_stop;
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    do_reset();
    chk("R1 reset value", rd_data, 8'hC3);
    chk("R1 pins", {dbg_pin_en, rst_pin_en}, 2'b11);

    // R5 long period from reset release, then R8 single pulse and restart
    wait_pulse(5000, k);
    chk("R5 long period", k, exp_period(1));
    @(negedge clk);
    chk("R8 single cycle", wdog_rst_req, 0);
    wait_pulse(5000, k);
    chk("R8 resumes from zero", k, exp_period(1) - 1);

    // R6 service restarts the count
    do_reset();
    for (int i = 0; i < 6; i++) begin
      repeat (($urandom % 200) + 10) @(negedge clk);
      wdog_service = 1; @(negedge clk); wdog_service = 0;
    end
    wait_pulse(5000, k);
    chk("R6 period after service", k, exp_period(1));

    // R2/R3/R4/R7/R9: disable everything
    do_reset();
    do_write(8'h1C);
    chk("R2 commit read", rd_data, exp_read(8'h1C, 8'h1C));
    chk("R3 pins cleared", {dbg_pin_en, rst_pin_en}, 2'b00);
    do_write(8'hFF);
    chk("R2 locked bits / R4 unimpl", rd_data, 8'h03);
    chk("R3 pins after lock", {dbg_pin_en, rst_pin_en}, 2'b11);
    quiet_window("R7 disabled no request", 3 * exp_period(1));
    stop_probe("R9 stop trap", 0);

    // R10/R11: enabled, short period, stop allowed; write lands mid-count
    do_reset();
    repeat (100) @(negedge clk);
    do_write(8'hA2);
    chk("R11 commit read", rd_data, 8'hA2);
    wait_pulse(5000, k);
    chk("R11 short period from commit", k, exp_period(0));
    stop_probe("R10 stop grant", 1);

    // Random phase: watchdog off, stop allowed, random writes and stops
    do_reset();
    do_write(8'h20);
    model = 8'h20;
    prev_stop = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R2/R3 random read", rd_data, model);
        chk("R10 random grant", stop_grant, prev_stop);
        chk("R9 random no trap", illop_rst_req, 0);
        chk("R7 random quiet", wdog_rst_req, 0);
      end
      wr_en = ($urandom % 3) == 0;
      wr_data = 8'($urandom);
      stop_req = ($urandom % 4) == 0;
      wdog_service = $urandom % 2;
      if (wr_en) model = exp_read(8'h20, wr_data);
      prev_stop = stop_req;
    end
    @(negedge clk);
    wr_en = 0; stop_req = 0; wdog_service = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule